// File: doc/BRIEF.md
# Private-cache line coherence controller

This block is the coherence state machine for one line of a private first-level cache in a directory-based MOESI system. It takes one encoded event per cycle. Events come from the processor (load, instruction fetch, store, replacement), from forwarded network traffic (shared or exclusive requests from other agents, DMA reads, the block's own exclusive request coming back, invalidations), from network responses (acknowledgements, shared or exclusive data, writeback acknowledge, acknowledge-with-data-request, writeback refusal) and from the local all-acks trigger. For each event it returns, in the same cycle, the request message to issue, the response message to send and a hit flag. It also returns a retry flag when the event has to be deferred. The new state is registered at the clock edge.

The event input is a valid-only stream, and the retry flag is its back-pressure. An event presented with `evt_valid` high while `retry_o` is high is not consumed and has no effect. The sender must hold it or present it again later. When `retry_o` is low, the event is consumed at the rising edge. After an exclusive fill, the block runs its own lockout timer. While the timer runs, foreign traffic is held off so that the local processor can use the line it just received. The data arrays, the network and the counting of acknowledgements stay outside the block. The block also keeps the line's dirty flag so that it can type a writeback.

Top module: `l1_line_coh`

## Requirements
- R1: After reset the state is I (code 0), the permission is none, the error flag is low, and with no event presented every command output is 0 and hit and retry are low. The state codes are I=0, S=1, O=2, M=3, M_W=4, MM=5, MM_W=6, IM=7, SM=8, OM=9, IS=10, SI=11, OI=12, MI=13, II=14.
- R2: `perm_o` is 2 (read-write) in MM and MM_W. It is 1 (read-only) in S, O, M, M_W, SM and OM. It is 0 (none) in every other state.
- R3: The event codes are load=0, ifetch=1, store=2, replace=3, fwd-shared=4, fwd-excl=5, fwd-dma=6, own-excl=7, invalidate=8, ack=9, data=10, excl-data=11, wb-ack=12, wb-ack-data=13, wb-nack=14, all-acks=15. In I, a load or ifetch moves to IS and issues request 1 (shared fetch). A store moves to IM and issues request 2 (exclusive fetch). A replacement stays in I with no message. An invalidate answers with response 3 (ack).
- R4: A store in S moves to SM, and a store in O moves to OM, each issuing request 2. A store in M moves to MM as a hit with no message. A store in M_W moves to MM_W as a hit. A store in MM or MM_W is a hit. Every store hit marks the line dirty.
- R5: A replacement in S moves to SI with request 3 (put-shared). In O it moves to OI with request 4 (put-owned). In M or MM it moves to MI with request 5 (put-modified).
- R6: Response codes are data=1, excl-data=2, ack=3, unblock=4, excl-unblock=5, wb-dirty=6, wb-clean=7. A fwd-excl in O, M or MM sends response 2 and moves to I. A fwd-shared in M sends response 1 and moves to O. A fwd-shared in MM sends response 2 and moves to I. A fwd-shared or fwd-dma in S, O, SM or OM sends response 1 and keeps the state. A fwd-dma in M or MM also sends response 1 and keeps the state. An invalidate in S moves to I and sends response 3. A fwd-excl in OM sends response 2 and moves to IM.
- R7: In IS, data moves to S with response 4, and excl-data moves to M_W with response 5. In IM or SM, either data event moves to OM. All-acks in OM moves to MM_W with response 5. Each fill loads the dirty flag from `evt_dirty`.
- R8: Each entry into M_W or MM_W starts a lockout of LOCK_CYCLES cycles. At the end of that window the line drops to M or MM. During the window, a replacement, forwarded request, own-excl or invalidate is retried. In the window's last cycle every event is retried.
- R9: In IM, IS, SI, OI, MI and II, loads, ifetches, stores and replacements are retried. In SM and OM, loads and ifetches are hits, and stores and replacements are retried.
- R10: In SI, OI or MI, wb-ack moves to I. wb-ack-data moves to I and sends response 6 if the line is dirty, or 7 if it is clean.
- R11: wb-nack moves MI or OI to OI and moves II to I. A fwd-shared in MI moves to OI and sends response 1. A fwd-excl in MI or OI moves to II and sends response 2. A fwd-shared or fwd-dma in OI, or a fwd-dma in MI, sends response 1 and keeps the state.
- R12: An event that is not legal in the current state sets `err_o` one cycle later and leaves the state unchanged. It issues no message and no retry. `err_o` stays high until reset.
- R13: A retried event issues no request, no response and no hit, and leaves the state unchanged. The only exception is the lockout expiry itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_code | input | 4 | Event code (R3) |
| evt_dirty | input | 1 | Dirty flag carried by a data fill |
| state_o | output | 4 | Current line state (R1 codes) |
| perm_o | output | 2 | Access permission: 0 none, 1 read-only, 2 read-write |
| req_cmd_o | output | 3 | Request message to issue this cycle, 0 for none |
| rsp_cmd_o | output | 3 | Response message to send this cycle, 0 for none |
| hit_o | output | 1 | Processor access served from the line |
| retry_o | output | 1 | Event deferred and not consumed |
| err_o | output | 1 | Sticky illegal-event flag |

## Verification
Some rules are checked on every cycle by assertions. Read-write permission appears only in the two modified states. A retried event is quiet and leaves the state unchanged. The error flag is sticky. A lockout window never runs longer than its length and always ends in M or MM. The bench's scenarios are needed for the rest: the exact message chosen for each state and event pair, the dirty or clean typing of a writeback that depends on earlier stores and fills, the race paths through MI, OI and II, and retries in the expiry cycle. The bench checks these with a reference model driven by random event streams and by directed sequences.

// File: rtl/l1c_pkg.sv
package l1c_pkg;
  typedef enum logic [3:0] {
    ST_I = 4'd0, ST_S = 4'd1, ST_O = 4'd2, ST_M = 4'd3, ST_MW = 4'd4,
    ST_MM = 4'd5, ST_MMW = 4'd6, ST_IM = 4'd7, ST_SM = 4'd8, ST_OM = 4'd9,
    ST_IS = 4'd10, ST_SI = 4'd11, ST_OI = 4'd12, ST_MI = 4'd13, ST_II = 4'd14
  } lstate_e;

  typedef enum logic [3:0] {
    EV_LOAD = 4'd0, EV_IFETCH = 4'd1, EV_STORE = 4'd2, EV_REPL = 4'd3,
    EV_FGETS = 4'd4, EV_FGETX = 4'd5, EV_FDMA = 4'd6, EV_OWNX = 4'd7,
    EV_INV = 4'd8, EV_ACK = 4'd9, EV_DATA = 4'd10, EV_XDATA = 4'd11,
    EV_WBACK = 4'd12, EV_WBDATA = 4'd13, EV_WBNACK = 4'd14, EV_ALLACK = 4'd15
  } levent_e;

  typedef enum logic [2:0] {
    RQ_NONE = 3'd0, RQ_GETS = 3'd1, RQ_GETX = 3'd2,
    RQ_PUTS = 3'd3, RQ_PUTO = 3'd4, RQ_PUTX = 3'd5
  } lreq_e;

  typedef enum logic [2:0] {
    RS_NONE = 3'd0, RS_DATA = 3'd1, RS_XDATA = 3'd2, RS_ACK = 3'd3,
    RS_UNBLK = 3'd4, RS_UNBLKX = 3'd5, RS_WBD = 3'd6, RS_WBC = 3'd7
  } lrsp_e;

  typedef enum logic [1:0] {
    PM_NONE = 2'd0, PM_RO = 2'd1, PM_RW = 2'd2
  } lperm_e;
endpackage

// File: rtl/l1c_perm.sv
module l1c_perm
  import l1c_pkg::*;
(
  input  lstate_e st,
  output lperm_e  perm
);
  always_comb begin
    unique case (st)
      ST_MM, ST_MMW:                              perm = PM_RW;
      ST_S, ST_O, ST_M, ST_MW, ST_SM, ST_OM:      perm = PM_RO;
      default:                                    perm = PM_NONE;
    endcase
  end
endmodule

// File: rtl/l1c_lock_tmr.sv
module l1c_lock_tmr #(
  parameter int LOCK_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_lock,
  output logic expire
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (start)                      cnt_q <= CW'(LOCK_CYCLES - 1);
    else if (in_lock && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expire = in_lock && (cnt_q == '0);
endmodule

// File: rtl/l1c_xtab.sv
module l1c_xtab
  import l1c_pkg::*;
(
  input  lstate_e st,
  input  levent_e ev,
  input  logic    ev_valid,
  input  logic    lock_expire,
  input  logic    dirty,
  output lstate_e nxt,
  output lreq_e   req,
  output lrsp_e   rsp,
  output logic    hit,
  output logic    retry,
  output logic    illegal,
  output logic    fill,
  output logic    set_dirty,
  output logic    start_lock
);
  always_comb begin
    nxt = st; req = RQ_NONE; rsp = RS_NONE;
    hit = 1'b0; retry = 1'b0; illegal = 1'b0;
    fill = 1'b0; set_dirty = 1'b0; start_lock = 1'b0;
    if (ev_valid && lock_expire) begin
      retry = 1'b1;
    end else if (ev_valid) begin
      unique case (st)
        ST_I: case (ev)
          EV_LOAD, EV_IFETCH: begin nxt = ST_IS; req = RQ_GETS; end
          EV_STORE:           begin nxt = ST_IM; req = RQ_GETX; end
          EV_REPL:            ;
          EV_INV:             rsp = RS_ACK;
          default:            illegal = 1'b1;
        endcase
        ST_S: case (ev)
          EV_LOAD, EV_IFETCH: hit = 1'b1;
          EV_STORE:           begin nxt = ST_SM; req = RQ_GETX; end
          EV_REPL:            begin nxt = ST_SI; req = RQ_PUTS; end
          EV_INV:             begin nxt = ST_I; rsp = RS_ACK; end
          EV_FGETS, EV_FDMA:  rsp = RS_DATA;
          default:            illegal = 1'b1;
        endcase
        ST_O: case (ev)
          EV_LOAD, EV_IFETCH: hit = 1'b1;
          EV_STORE:           begin nxt = ST_OM; req = RQ_GETX; end
          EV_REPL:            begin nxt = ST_OI; req = RQ_PUTO; end
          EV_FGETX:           begin nxt = ST_I; rsp = RS_XDATA; end
          EV_FGETS, EV_FDMA:  rsp = RS_DATA;
          default:            illegal = 1'b1;
        endcase
        ST_M, ST_MM: case (ev)
          EV_LOAD, EV_IFETCH: hit = 1'b1;
          EV_STORE:           begin nxt = ST_MM; hit = 1'b1; set_dirty = 1'b1; end
          EV_REPL:            begin nxt = ST_MI; req = RQ_PUTX; end
          EV_FGETX:           begin nxt = ST_I; rsp = RS_XDATA; end
          EV_FGETS: begin
            if (st == ST_M) begin nxt = ST_O; rsp = RS_DATA; end
            else            begin nxt = ST_I; rsp = RS_XDATA; end
          end
          EV_FDMA:            rsp = RS_DATA;
          default:            illegal = 1'b1;
        endcase
        ST_MW, ST_MMW: case (ev)
          EV_LOAD, EV_IFETCH: hit = 1'b1;
          EV_STORE:           begin nxt = ST_MMW; hit = 1'b1; set_dirty = 1'b1; end
          EV_REPL, EV_FGETS, EV_FGETX, EV_FDMA, EV_OWNX, EV_INV: retry = 1'b1;
          default:            illegal = 1'b1;
        endcase
        ST_IM: case (ev)
          EV_LOAD, EV_IFETCH, EV_STORE, EV_REPL: retry = 1'b1;
          EV_INV:             rsp = RS_ACK;
          EV_ACK:             ;
          EV_DATA, EV_XDATA:  begin nxt = ST_OM; fill = 1'b1; end
          default:            illegal = 1'b1;
        endcase
        ST_SM: case (ev)
          EV_LOAD, EV_IFETCH: hit = 1'b1;
          EV_STORE, EV_REPL:  retry = 1'b1;
          EV_INV:             begin nxt = ST_IM; rsp = RS_ACK; end
          EV_ACK:             ;
          EV_DATA, EV_XDATA:  begin nxt = ST_OM; fill = 1'b1; end
          EV_FGETS, EV_FDMA:  rsp = RS_DATA;
          default:            illegal = 1'b1;
        endcase
        ST_OM: case (ev)
          EV_LOAD, EV_IFETCH: hit = 1'b1;
          EV_STORE, EV_REPL:  retry = 1'b1;
          EV_OWNX, EV_ACK:    ;
          EV_FGETX:           begin nxt = ST_IM; rsp = RS_XDATA; end
          EV_FGETS, EV_FDMA:  rsp = RS_DATA;
          EV_ALLACK:          begin nxt = ST_MMW; rsp = RS_UNBLKX; start_lock = 1'b1; end
          default:            illegal = 1'b1;
        endcase
        ST_IS: case (ev)
          EV_LOAD, EV_IFETCH, EV_STORE, EV_REPL: retry = 1'b1;
          EV_INV:             rsp = RS_ACK;
          EV_DATA:            begin nxt = ST_S; rsp = RS_UNBLK; fill = 1'b1; end
          EV_XDATA: begin
            nxt = ST_MW; rsp = RS_UNBLKX; fill = 1'b1; start_lock = 1'b1;
          end
          default:            illegal = 1'b1;
        endcase
        ST_SI, ST_OI, ST_MI: case (ev)
          EV_LOAD, EV_IFETCH, EV_STORE, EV_REPL: retry = 1'b1;
          EV_WBACK:           nxt = ST_I;
          EV_WBDATA:          begin nxt = ST_I; rsp = dirty ? RS_WBD : RS_WBC; end
          EV_WBNACK: begin
            if (st == ST_SI) illegal = 1'b1;
            else             nxt = ST_OI;
          end
          EV_FGETX: begin
            if (st == ST_SI) illegal = 1'b1;
            else begin nxt = ST_II; rsp = RS_XDATA; end
          end
          EV_FGETS: begin
            if (st == ST_SI) illegal = 1'b1;
            else begin nxt = ST_OI; rsp = RS_DATA; end
          end
          EV_FDMA: begin
            if (st == ST_SI) illegal = 1'b1;
            else             rsp = RS_DATA;
          end
          default:            illegal = 1'b1;
        endcase
        ST_II: case (ev)
          EV_LOAD, EV_IFETCH, EV_STORE, EV_REPL: retry = 1'b1;
          EV_WBNACK:          nxt = ST_I;
          default:            illegal = 1'b1;
        endcase
        default: illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/l1_line_coh.sv
module l1_line_coh
  import l1c_pkg::*;
#(
  parameter int LOCK_CYCLES = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_valid,
  input  logic [3:0] evt_code,
  input  logic       evt_dirty,
  output logic [3:0] state_o,
  output logic [1:0] perm_o,
  output logic [2:0] req_cmd_o,
  output logic [2:0] rsp_cmd_o,
  output logic       hit_o,
  output logic       retry_o,
  output logic       err_o
);
  lstate_e st_q, x_nxt;
  lreq_e   x_req;
  lrsp_e   x_rsp;
  lperm_e  perm;
  logic    dirty_q, err_q;
  logic    x_hit, x_retry, x_ill, x_fill, x_sd, x_start;
  logic    in_lock, expire, consume;

  assign in_lock = (st_q == ST_MW) || (st_q == ST_MMW);
  assign consume = evt_valid && !x_retry && !x_ill;

  l1c_lock_tmr #(.LOCK_CYCLES(LOCK_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(x_start), .in_lock(in_lock), .expire(expire)
  );

  l1c_xtab u_xtab (
    .st(st_q), .ev(levent_e'(evt_code)), .ev_valid(evt_valid),
    .lock_expire(expire), .dirty(dirty_q),
    .nxt(x_nxt), .req(x_req), .rsp(x_rsp), .hit(x_hit), .retry(x_retry),
    .illegal(x_ill), .fill(x_fill), .set_dirty(x_sd), .start_lock(x_start)
  );

  l1c_perm u_perm (.st(st_q), .perm(perm));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_I;
      dirty_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= err_q | x_ill;
      if (expire) begin
        st_q <= (st_q == ST_MW) ? ST_M : ST_MM;
      end else if (consume) begin
        st_q <= x_nxt;
        if (x_nxt == ST_I) dirty_q <= 1'b0;
        else if (x_sd)     dirty_q <= 1'b1;
        else if (x_fill)   dirty_q <= evt_dirty;
      end
    end
  end

  assign state_o   = st_q;
  assign perm_o    = perm;
  assign req_cmd_o = x_req;
  assign rsp_cmd_o = x_rsp;
  assign hit_o     = x_hit;
  assign retry_o   = x_retry;
  assign err_o     = err_q;
endmodule

// File: rtl/l1_line_coh_chk.sv
module l1_line_coh_chk #(
  parameter int LOCK_CYCLES = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_valid,
  input logic [3:0] state_o,
  input logic [1:0] perm_o,
  input logic [2:0] req_cmd_o,
  input logic [2:0] rsp_cmd_o,
  input logic       hit_o,
  input logic       retry_o,
  input logic       err_o
);
  localparam int LW = $clog2(LOCK_CYCLES + 1) + 1;
  logic [LW-1:0] lk_cnt;
  logic          locked, last_lock;

  assign locked    = (state_o == 4'd4) || (state_o == 4'd6);
  assign last_lock = locked && (lk_cnt == LW'(LOCK_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      lk_cnt <= '0;
    else if (locked) lk_cnt <= lk_cnt + 1'b1;
    else             lk_cnt <= '0;
  end

  // R2
  rw_only_modified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_o == 2'd2 |-> (state_o == 4'd5 || state_o == 4'd6));

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  // R13
  retry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_o |-> (req_cmd_o == 3'd0 && rsp_cmd_o == 3'd0 && !hit_o));

  // R13
  retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && retry_o && !last_lock) |=> $stable(state_o));

  // R8
  lock_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> lk_cnt < LW'(LOCK_CYCLES));

  // R8
  lock_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_lock |=> (state_o == 4'd3 || state_o == 4'd5));
endmodule

bind l1_line_coh l1_line_coh_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .state_o(state_o),
  .perm_o(perm_o), .req_cmd_o(req_cmd_o), .rsp_cmd_o(rsp_cmd_o),
  .hit_o(hit_o), .retry_o(retry_o), .err_o(err_o)
);

// File: tb/l1_line_coh_tb.sv
module l1_line_coh_tb;
  localparam int LOCK = 50;
  localparam int S_I=0, S_S=1, S_O=2, S_M=3, S_MW=4, S_MM=5, S_MMW=6, S_IM=7,
                 S_SM=8, S_OM=9, S_IS=10, S_SI=11, S_OI=12, S_MI=13, S_II=14;
  localparam int E_LD=0, E_IF=1, E_ST=2, E_RP=3, E_FGS=4, E_FGX=5, E_FDM=6,
                 E_OWN=7, E_INV=8, E_ACK=9, E_DAT=10, E_XDT=11, E_WBA=12,
                 E_WBD=13, E_WBN=14, E_ALL=15;
  localparam int Q_GETS=1, Q_GETX=2, Q_PUTS=3, Q_PUTO=4, Q_PUTX=5;
  localparam int P_DAT=1, P_XDT=2, P_ACK=3, P_UNB=4, P_UNBX=5, P_WBD=6, P_WBC=7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_valid = 1'b0;
  logic [3:0] evt_code = '0;
  logic       evt_dirty = 1'b0;
  logic [3:0] state_o;
  logic [1:0] perm_o;
  logic [2:0] req_cmd_o, rsp_cmd_o;
  logic       hit_o, retry_o, err_o;

  always #4 clk = ~clk;

  l1_line_coh #(.LOCK_CYCLES(LOCK)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .evt_dirty(evt_dirty), .state_o(state_o), .perm_o(perm_o),
    .req_cmd_o(req_cmd_o), .rsp_cmd_o(rsp_cmd_o), .hit_o(hit_o),
    .retry_o(retry_o), .err_o(err_o)
  );

  int n_chk = 0, n_fail = 0;
  int m_st, m_lcnt;
  bit m_dirty, m_err;
  int e_nx, e_rq, e_rs;
  bit e_hit, e_rt, e_il, e_fill, e_sd, e_lk;
  string tag;

  task automatic chk(input bit ok, input string tg, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tg, what, act, exp);
    end
  endtask

  function automatic int perm_of(input int s);
    if (s == S_MM || s == S_MMW) return 2;
    if (s inside {S_S, S_O, S_M, S_MW, S_SM, S_OM}) return 1;
    return 0;
  endfunction

  function automatic bit locked(input int s);
    return s == S_MW || s == S_MMW;
  endfunction

  task automatic predict(input bit v, input int ev);
    bit proc;
    e_nx = m_st; e_rq = 0; e_rs = 0; e_hit = 0; e_rt = 0; e_il = 0;
    e_fill = 0; e_sd = 0; e_lk = 0; tag = "R13";
    if (!v) return;
    if (locked(m_st) && m_lcnt == 0) begin e_rt = 1; tag = "R8"; return; end
    proc = ev inside {E_LD, E_IF, E_ST, E_RP};
    if (m_st == S_I) begin
      tag = "R3";
      if (ev == E_LD || ev == E_IF) begin e_nx = S_IS; e_rq = Q_GETS; end
      else if (ev == E_ST) begin e_nx = S_IM; e_rq = Q_GETX; end
      else if (ev == E_RP) ;
      else if (ev == E_INV) e_rs = P_ACK;
      else e_il = 1;
    end else if (m_st inside {S_S, S_O, S_M, S_MM}) begin
      tag = "R6";
      if (ev == E_LD || ev == E_IF) begin e_hit = 1; tag = "R4"; end
      else if (ev == E_ST) begin
        tag = "R4";
        if (m_st == S_S) begin e_nx = S_SM; e_rq = Q_GETX; end
        else if (m_st == S_O) begin e_nx = S_OM; e_rq = Q_GETX; end
        else begin e_nx = S_MM; e_hit = 1; e_sd = 1; end
      end else if (ev == E_RP) begin
        tag = "R5";
        if (m_st == S_S) begin e_nx = S_SI; e_rq = Q_PUTS; end
        else if (m_st == S_O) begin e_nx = S_OI; e_rq = Q_PUTO; end
        else begin e_nx = S_MI; e_rq = Q_PUTX; end
      end else if (ev == E_FDM) e_rs = P_DAT;
      else if (ev == E_FGS) begin
        if (m_st == S_M) begin e_nx = S_O; e_rs = P_DAT; end
        else if (m_st == S_MM) begin e_nx = S_I; e_rs = P_XDT; end
        else e_rs = P_DAT;
      end else if (ev == E_FGX && m_st != S_S) begin e_nx = S_I; e_rs = P_XDT; end
      else if (ev == E_INV && m_st == S_S) begin e_nx = S_I; e_rs = P_ACK; end
      else e_il = 1;
    end else if (locked(m_st)) begin
      tag = "R8";
      if (ev == E_LD || ev == E_IF) e_hit = 1;
      else if (ev == E_ST) begin e_nx = S_MMW; e_hit = 1; e_sd = 1; tag = "R4"; end
      else if (ev inside {E_RP, E_FGS, E_FGX, E_FDM, E_OWN, E_INV}) e_rt = 1;
      else e_il = 1;
    end else if (m_st == S_SM || m_st == S_OM) begin
      tag = "R9";
      if (ev == E_LD || ev == E_IF) e_hit = 1;
      else if (ev == E_ST || ev == E_RP) e_rt = 1;
      else if (ev == E_FGS || ev == E_FDM) begin e_rs = P_DAT; tag = "R6"; end
      else if (ev == E_ACK) ;
      else if (m_st == S_SM && ev == E_INV) begin e_nx = S_IM; e_rs = P_ACK; end
      else if (m_st == S_SM && (ev == E_DAT || ev == E_XDT)) begin
        e_nx = S_OM; e_fill = 1; tag = "R7";
      end else if (m_st == S_OM && ev == E_OWN) ;
      else if (m_st == S_OM && ev == E_FGX) begin e_nx = S_IM; e_rs = P_XDT; tag = "R6"; end
      else if (m_st == S_OM && ev == E_ALL) begin
        e_nx = S_MMW; e_rs = P_UNBX; e_lk = 1; tag = "R7";
      end else e_il = 1;
    end else if (proc) begin
      e_rt = 1; tag = "R9";
    end else if (m_st == S_IM) begin
      tag = "R7";
      if (ev == E_INV) e_rs = P_ACK;
      else if (ev == E_ACK) ;
      else if (ev == E_DAT || ev == E_XDT) begin e_nx = S_OM; e_fill = 1; end
      else e_il = 1;
    end else if (m_st == S_IS) begin
      tag = "R7";
      if (ev == E_INV) e_rs = P_ACK;
      else if (ev == E_DAT) begin e_nx = S_S; e_rs = P_UNB; e_fill = 1; end
      else if (ev == E_XDT) begin e_nx = S_MW; e_rs = P_UNBX; e_fill = 1; e_lk = 1; end
      else e_il = 1;
    end else if (m_st == S_II) begin
      tag = "R11";
      if (ev == E_WBN) e_nx = S_I; else e_il = 1;
    end else begin
      tag = "R10";
      if (ev == E_WBA) e_nx = S_I;
      else if (ev == E_WBD) begin e_nx = S_I; e_rs = m_dirty ? P_WBD : P_WBC; end
      else if (m_st == S_SI) e_il = 1;
      else begin
        tag = "R11";
        if (ev == E_WBN) e_nx = S_OI;
        else if (ev == E_FGX) begin e_nx = S_II; e_rs = P_XDT; end
        else if (ev == E_FGS) begin e_nx = S_OI; e_rs = P_DAT; end
        else if (ev == E_FDM) e_rs = P_DAT;
        else e_il = 1;
      end
    end
    if (e_il) tag = "R12";
  endtask

  task automatic step(input bit v, input int ev, input bit ed);
    bit expire, was_lock;
    string t;
    @(negedge clk);
    evt_valid = v; evt_code = 4'(ev); evt_dirty = ed;
    predict(v, ev);
    was_lock = locked(m_st);
    expire = was_lock && m_lcnt == 0;
    #2;
    chk(int'(req_cmd_o) == e_rq, tag, "request", int'(req_cmd_o), e_rq);
    chk(int'(rsp_cmd_o) == e_rs, tag, "response", int'(rsp_cmd_o), e_rs);
    chk(hit_o == e_hit, tag, "hit", int'(hit_o), int'(e_hit));
    chk(retry_o == e_rt, tag, "retry", int'(retry_o), int'(e_rt));
    chk(int'(perm_o) == perm_of(m_st), "R2", "perm", int'(perm_o), perm_of(m_st));
    chk(err_o == m_err, "R12", "err", int'(err_o), int'(m_err));
    @(posedge clk);
    if (expire) m_st = (m_st == S_MW) ? S_M : S_MM;
    else if (v && !e_rt && !e_il) begin
      m_st = e_nx;
      if (e_nx == S_I) m_dirty = 0;
      else if (e_sd) m_dirty = 1;
      else if (e_fill) m_dirty = ed;
    end
    m_err = m_err | e_il;
    if (e_lk) m_lcnt = LOCK - 1;
    else if (was_lock && m_lcnt != 0) m_lcnt--;
    t = e_rt ? "R13" : (expire ? "R8" : tag);
    #1;
    chk(int'(state_o) == m_st, t, "state", int'(state_o), m_st);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; evt_valid = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_st = S_I; m_dirty = 0; m_err = 0; m_lcnt = 0;
    #1;
    // R1 reset state and idle outputs
    chk(state_o == 4'd0, "R1", "state", int'(state_o), 0);
    chk(perm_o == 2'd0, "R1", "perm", int'(perm_o), 0);
    chk(err_o == 1'b0, "R1", "err", int'(err_o), 0);
    chk(req_cmd_o == 3'd0 && rsp_cmd_o == 3'd0 && !hit_o && !retry_o,
        "R1", "idle outputs", int'({req_cmd_o, rsp_cmd_o, hit_o, retry_o}), 0);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h51c0ffee));
    do_reset();
    // R3 R7 R8: exclusive fill, retried forward during lockout, drop to M
    step(1, E_LD, 0); step(1, E_XDT, 0); step(1, E_FGS, 0);
    idle(LOCK);
    // R4 R5 R10: silent store, replacement, dirty writeback
    step(1, E_ST, 0); step(1, E_RP, 0); step(1, E_LD, 0); step(1, E_WBD, 0);
    // R3 R7 R4 R6: store miss path through OM to MM_W, store in lockout, GETS in MM
    step(1, E_ST, 0); step(1, E_ACK, 0); step(1, E_DAT, 1); step(1, E_OWN, 0);
    step(1, E_ALL, 0); step(1, E_ST, 0); step(1, E_INV, 0);
    idle(LOCK); step(1, E_FGS, 0);
    // R5 R10: shared line, clean writeback
    step(1, E_IF, 0); step(1, E_DAT, 0); step(1, E_FDM, 0); step(1, E_RP, 0);
    step(1, E_WBD, 0);
    // R8 R9 R11: loads through whole lockout incl. expiry cycle, MI races
    step(1, E_LD, 0); step(1, E_ST, 0); step(1, E_XDT, 0);
    for (int k = 0; k < LOCK; k++) step(1, E_LD, 0);
    step(1, E_RP, 0); step(1, E_FGS, 0); step(1, E_WBN, 0); step(1, E_FGX, 0);
    step(1, E_LD, 0); step(1, E_WBN, 0);
    // R12: illegal ack in I, then sticky
    step(1, E_ACK, 0); step(1, E_LD, 0); step(0, 0, 0);
    do_reset();
    // random mix, biased toward legal events
    for (int i = 0; i < 6000; i++) begin
      bit v, ed;
      int ev;
      if (m_err) do_reset();
      v = ($urandom % 8) != 0;
      ev = $urandom % 16;
      ed = $urandom % 2;
      for (int k = 0; k < 6; k++) begin
        predict(v, ev);
        if (!e_il) break;
        ev = $urandom % 16;
      end
      step(v, ev, ed);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule